// File: doc/BRIEF.md
# Fast Ethernet 4B/5B Transmit Encoder

This block sits in the transmit path of a 100 Mb/s physical layer, between the nibble-wide MAC-side interface and the scrambler. On every 25 MHz cycle it samples one transmit nibble together with its enable and error flags. It then emits exactly one registered 5-bit code group. The enable flag frames a packet. On its rising edge the first two nibble slots become the start delimiter pair. Data nibbles are translated through the 4B/5B table. When the enable drops, the end delimiter pair fills the first two slots that would otherwise carry idle. Between packets the output carries idle codes without a break.

An error flag raised during the data phase replaces the translated code with the error code. A bypass input skips translation and framing entirely and registers a raw 5-bit word straight to the output. The stream runs at a fixed rate and has no back-pressure. The downstream serializer takes one code group per cycle unconditionally, so neither side has a ready signal and every cycle is a valid transfer.

Top module: `fe_tx_encoder`

## Requirements
- R1: A synchronous active-high `rst` forces `code_out` to the idle code 11111 on the next clock edge, and the framer returns to its between-packets state.
- R2: Every output follows from the inputs sampled at the previous rising edge; the encoder has exactly one cycle of latency.
- R3: While `tx_en` is low and no end delimiter is pending, `code_out` is idle (11111) on every cycle.
- R4: The first two cycles with `tx_en` high after an idle period produce J (11000) and then K (10001). The nibble values and `tx_er` in those two cycles have no effect on the output.
- R5: In the data phase (third and later cycle of `tx_en` high), nibble 0..F maps to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: In the data phase, `tx_er` high replaces the translated code with H (00100).
- R7: The first cycle with `tx_en` low after a frame produces T (01101), the next produces R (00111), and idle follows. This also holds when `tx_en` fell after only one or two cycles.
- R8: During the R slot `tx_en` is ignored. A frame whose enable is already high in that slot starts with J in the following slot.
- R9: With `bypass` high, `code_out` takes the value of `raw_code` from the previous cycle, and `tx_en`, `tx_er` and `tx_nib` are ignored.
- R10: Leaving bypass puts the framer in the between-packets state. A `tx_en` already high then starts a new frame with J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz code-group clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Frame enable from the MAC side |
| tx_er | input | 1 | Transmit error flag |
| tx_nib | input | 4 | Transmit data nibble |
| bypass | input | 1 | Skip translation and pass `raw_code` |
| raw_code | input | 5 | Raw code group used in bypass |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
The table is exercised by a frame that walks all sixteen nibbles, which separates a wrong or swapped entry from a framing fault. Frames of one, two and many enable cycles tell apart the start delimiter, the end delimiter and their collision in very short packets. Errors are placed both in the delimiter slots and in the data slots, which shows that only data-phase errors produce H. Bypass is entered in mid-frame and left with the enable held high, which exposes a framer that keeps stale state. Back-to-back frames whose enable returns during the R slot check the restart rule.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] C_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] C_J    = 5'b11000;
  localparam logic [CODE_W-1:0] C_K    = 5'b10001;
  localparam logic [CODE_W-1:0] C_T    = 5'b01101;
  localparam logic [CODE_W-1:0] C_R    = 5'b00111;
  localparam logic [CODE_W-1:0] C_H    = 5'b00100;

  // Which code the output register loads next
  typedef enum logic [2:0] {
    SEL_IDLE, SEL_J, SEL_K, SEL_DATA, SEL_ERR, SEL_T, SEL_R
  } code_sel_e;

  typedef enum logic [1:0] {
    ST_GAP, ST_SSD2, ST_BODY, ST_ESD2
  } frame_st_e;
endpackage

// File: rtl/fe_tx_nibble_map.sv
module fe_tx_nibble_map
  import fe_tx_pkg::*;
(
  input  logic [NIB_W-1:0]  nib,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    unique case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end
endmodule

// File: rtl/fe_tx_frame_ctl.sv
module fe_tx_frame_ctl
  import fe_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      er,
  input  logic      hold,
  output code_sel_e sel
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    sel  = SEL_IDLE;
    unique case (st_q)
      ST_GAP: begin
        if (en) begin
          sel  = SEL_J;
          st_d = ST_SSD2;
        end
      end
      ST_SSD2: begin
        if (en) begin
          sel  = SEL_K;
          st_d = ST_BODY;
        end else begin
          sel  = SEL_T;
          st_d = ST_ESD2;
        end
      end
      ST_BODY: begin
        if (en) begin
          sel = er ? SEL_ERR : SEL_DATA;
        end else begin
          sel  = SEL_T;
          st_d = ST_ESD2;
        end
      end
      default: begin
        sel  = SEL_R;
        st_d = ST_GAP;
      end
    endcase
    if (hold) st_d = ST_GAP;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_GAP;
    else     st_q <= st_d;
  end

  // R7
  esd_after_body_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BODY && !en && !hold) |=> (st_q == ST_ESD2));
endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder
  import fe_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  tx_nib,
  input  logic              bypass,
  input  logic [CODE_W-1:0] raw_code,
  output logic [CODE_W-1:0] code_out
);
  code_sel_e         sel;
  logic [CODE_W-1:0] data_code;
  logic [CODE_W-1:0] next_code;

  fe_tx_nibble_map u_map (
    .nib  (tx_nib),
    .code (data_code)
  );

  fe_tx_frame_ctl u_ctl (
    .clk  (clk),
    .rst  (rst),
    .en   (tx_en),
    .er   (tx_er),
    .hold (bypass),
    .sel  (sel)
  );

  always_comb begin
    unique case (sel)
      SEL_J:    next_code = C_J;
      SEL_K:    next_code = C_K;
      SEL_DATA: next_code = data_code;
      SEL_ERR:  next_code = C_H;
      SEL_T:    next_code = C_T;
      SEL_R:    next_code = C_R;
      default:  next_code = C_IDLE;
    endcase
    if (bypass) next_code = raw_code;
  end

  always_ff @(posedge clk) begin
    if (rst) code_out <= C_IDLE;
    else     code_out <= next_code;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_out == C_IDLE));

  // R9
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (code_out == $past(raw_code)));

  // R4
  k_after_j_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == C_K && !$past(bypass) && !$past(rst)) |-> ($past(code_out) == C_J));

  // R7
  r_after_t_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == C_T && !bypass && !$past(bypass) && !$past(rst)) |=> (code_out == C_R));
endmodule

// File: tb/fe_tx_encoder_test.sv
module fe_tx_encoder_test;
  localparam time PERIOD = 40ns;
  localparam logic [4:0] TBL [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                      5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                      5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                      5'b11010, 5'b11011, 5'b11100, 5'b11101};

  logic clk = 0;
  logic rst = 1;
  logic tx_en = 0, tx_er = 0, bypass = 0;
  logic [3:0] tx_nib = 0;
  logic [4:0] raw_code = 0;
  logic [4:0] code_out;

  int vectors = 0;
  int misses  = 0;
  string tag = "R1";
  logic [4:0] exp_code = 5'b11111;
  int phase = 0; // 0 gap, 1 second delimiter slot, 2 body, 3 closing slot

  always #(PERIOD/2) clk = ~clk;

  fe_tx_encoder uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er), .tx_nib(tx_nib),
    .bypass(bypass), .raw_code(raw_code), .code_out(code_out)
  );

  // Behavioural reference, R2: one register of latency
  always @(posedge clk) begin
    if (rst) begin
      exp_code <= 5'b11111; phase <= 0;
    end else if (bypass) begin
      exp_code <= raw_code; phase <= 0;
    end else begin
      case (phase)
        0: if (tx_en) begin exp_code <= 5'b11000; phase <= 1; end
           else exp_code <= 5'b11111;
        1: if (tx_en) begin exp_code <= 5'b10001; phase <= 2; end
           else begin exp_code <= 5'b01101; phase <= 3; end
        2: if (tx_en) exp_code <= tx_er ? 5'b00100 : TBL[tx_nib];
           else begin exp_code <= 5'b01101; phase <= 3; end
        default: begin exp_code <= 5'b00111; phase <= 0; end
      endcase
    end
  end

  task automatic step(input logic en, input logic er, input logic [3:0] nib,
                      input logic byp, input logic [4:0] raw, input string t);
    @(negedge clk);
    vectors++;
    if (code_out !== exp_code) begin
      misses++;
      $display("FAIL %s: code_out=%b expected=%b at %0t", tag, code_out, exp_code, $time);
    end
    tag = t;
    tx_en = en; tx_er = er; tx_nib = nib; bypass = byp; raw_code = raw;
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) step(0, 0, 4'h0, 0, 5'h0, t);
  endtask

  initial begin
    #(PERIOD*200000);
    misses++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1: reset state
    step(1, 1, 4'h5, 0, 5'h0, "R1");
    step(1, 0, 4'h5, 0, 5'h0, "R1");
    rst = 0;
    idle(3, "R3");
    // R4 R5: frame walking all nibbles, noise and error in delimiter slots
    step(1, 1, 4'hA, 0, 5'h0, "R4");
    step(1, 1, 4'h3, 0, 5'h0, "R4");
    for (int i = 0; i < 16; i++) step(1, 0, 4'(i), 0, 5'h0, "R5");
    // R6: error mid-data
    step(1, 1, 4'h7, 0, 5'h0, "R6");
    step(1, 0, 4'h7, 0, 5'h0, "R6");
    step(0, 0, 4'h0, 0, 5'h0, "R7");
    idle(4, "R7");
    // R7: one-cycle and two-cycle frames
    step(1, 0, 4'h5, 0, 5'h0, "R7");
    idle(4, "R7");
    step(1, 0, 4'h5, 0, 5'h0, "R7");
    step(1, 0, 4'h5, 0, 5'h0, "R7");
    idle(4, "R7");
    // R8: enable returns during the R slot
    step(1, 0, 4'h1, 0, 5'h0, "R8");
    step(1, 0, 4'h2, 0, 5'h0, "R8");
    step(1, 0, 4'h3, 0, 5'h0, "R8");
    step(0, 0, 4'h0, 0, 5'h0, "R8");
    step(1, 0, 4'h4, 0, 5'h0, "R8");
    for (int i = 0; i < 4; i++) step(1, 0, 4'(i + 8), 0, 5'h0, "R8");
    // R9: bypass entered mid-frame, framing inputs active
    for (int i = 0; i < 8; i++) step(1, i[0], 4'(i), 1, 5'(i * 5 + 3), "R9");
    // R10: leave bypass with enable held
    for (int i = 0; i < 4; i++) step(1, 0, 4'(i + 2), 0, 5'h0, "R10");
    idle(4, "R3");
    // R1: reset in mid-frame
    step(1, 0, 4'h9, 0, 5'h0, "R1");
    step(1, 0, 4'h9, 0, 5'h0, "R1");
    step(1, 0, 4'h9, 0, 5'h0, "R1");
    rst = 1;
    step(1, 0, 4'h9, 0, 5'h0, "R1");
    rst = 0;
    idle(4, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule